// File: doc/BRIEF.md
# Row/Column Multiplexed-Address Memory

This block is a one-bit-wide memory whose word address is delivered in two halves over a single narrow set of address pins. The row half comes first and is captured by an active-low row strobe. The column half follows on the same pins and is captured by an active-low column strobe. The default size is 65,536 words, held as 256 rows of 256 bits. The interface has one data input, one data output and a read/write level. There is no separate memory-enable: a falling column strobe while the row strobe is low is what starts an access.

The strobes, pins, read/write level and data input are delayed together through a configurable synchroniser, so they stay aligned with each other. All capture decisions are taken on the falling edges of the synchronised strobes. The storage is kept as one row-wide word per row, and a column selects one bit inside it. The word address is row × 2^COL_BITS + column, which is row × 256 + column at the defaults.

Top module: `mux_addr_mem`

## Requirements
- R1: While reset is asserted, and on the first sample after it, `dout` is 0.
- R2: On a falling edge of the synchronised row strobe, the low ROW_BITS of the address pins are loaded into the row register. Pin changes after that edge do not alter the row used.
- R3: The column register is loaded from the low COL_BITS of the pins only on a falling edge of the column strobe while the row strobe is low. The word accessed is row × 2^COL_BITS + column.
- R4: If `wr_n` is 0 at the moment of that column fall, the `din` sampled at the same moment is stored into the addressed word. Every other word keeps its value.
- R5: If `wr_n` is 1 at the column fall, the addressed word appears on `dout` no later than SYNC_STAGES + 2 clock edges after the strobe fall is first sampled. It is held there while the column strobe stays low.
- R6: `dout` is 0 whenever the synchronised column strobe is high, and it stays 0 through a write access.
- R7: A column-strobe fall while the row strobe is high starts no access: nothing is written and `dout` stays 0.
- R8: Address-pin changes while both strobes stay low have no effect on the stored data or on `dout`.
- R9: Stored words keep their values across any number of later row and column cycles that address other words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_pins | input | max(ROW_BITS,COL_BITS) | Shared row/column address pins |
| row_strobe_n | input | 1 | Active-low row address strobe |
| col_strobe_n | input | 1 | Active-low column address strobe |
| wr_n | input | 1 | 0 selects write, 1 selects read, sampled at column fall |
| din | input | 1 | Write data bit |
| dout | output | 1 | Read data bit, 0 while the column strobe is high |

## Verification
The bench uses a reduced configuration with 16 rows and 16 columns. It first writes an arithmetic bit pattern into every word, then reads all of them back. A mismatch here shows a wrong row/column combination or a lost write. A second sweep inverts only the even rows and reads the whole array again. This separates correct row selection from writes that spill into neighbouring rows. Targeted sequences then change the pins while the strobes stay low, and drop the column strobe while the row strobe is high. These show that only the strobe edges capture addresses and start accesses.

// File: rtl/mam_pkg.sv
package mam_pkg;

   typedef enum logic {
      OP_WRITE = 1'b0,
      OP_READ  = 1'b1
   } mam_op_e;

   function automatic int unsigned mam_max(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/mam_delay.sv
module mam_delay #(
   parameter int unsigned WIDTH   = 1,
   parameter int unsigned STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (WIDTH < 1) begin : g_bad_width
      $error("mam_delay: WIDTH must be at least 1");
   end

   if (STAGES == 0) begin : g_pass
      assign q = d;
   end else begin : g_chain
      logic [WIDTH-1:0] pipe [STAGES];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < int'(STAGES); i++) begin
               pipe[i] <= RST_VAL;
            end
         end else begin
            pipe[0] <= d;
            for (int i = 1; i < int'(STAGES); i++) begin
               pipe[i] <= pipe[i-1];
            end
         end
      end

      assign q = pipe[STAGES-1];
   end

endmodule

// File: rtl/mam_addr_regs.sv
module mam_addr_regs
   import mam_pkg::*;
#(
   parameter int unsigned ROW_BITS = 8,
   parameter int unsigned COL_BITS = 8,
   parameter int unsigned PIN_BITS = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                row_s,
   input  logic                col_s,
   input  logic [PIN_BITS-1:0] pins_s,
   input  logic                rw_s,
   input  logic                din_s,
   output logic [ROW_BITS-1:0] row_addr,
   output logic [COL_BITS-1:0] col_addr,
   output logic                row_fall,
   output logic                col_fall,
   output logic                go,
   output mam_op_e             go_op,
   output logic                go_din
);

   if (PIN_BITS < ROW_BITS || PIN_BITS < COL_BITS) begin : g_bad_pins
      $error("mam_addr_regs: PIN_BITS narrower than an address half");
   end

   logic row_prev;
   logic col_prev;
   logic access;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row_prev <= 1'b1;
         col_prev <= 1'b1;
      end else begin
         row_prev <= row_s;
         col_prev <= col_s;
      end
   end

   assign row_fall = row_prev & ~row_s;
   assign col_fall = col_prev & ~col_s;
   assign access   = col_fall & ~row_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row_addr <= '0;
         col_addr <= '0;
         go       <= 1'b0;
         go_op    <= OP_READ;
         go_din   <= 1'b0;
      end else begin
         go <= access;
         if (row_fall) begin
            row_addr <= pins_s[ROW_BITS-1:0];
         end
         if (access) begin
            col_addr <= pins_s[COL_BITS-1:0];
            go_op    <= rw_s ? OP_READ : OP_WRITE;
            go_din   <= din_s;
         end
      end
   end

endmodule

// File: rtl/mam_cell_array.sv
module mam_cell_array #(
   parameter int unsigned ROW_BITS = 8,
   parameter int unsigned COL_BITS = 8
) (
   input  logic                clk,
   input  logic [ROW_BITS-1:0] row,
   input  logic [COL_BITS-1:0] col,
   input  logic                we,
   input  logic                wdata,
   output logic                rdata
);

   localparam int unsigned ROWS = 1 << ROW_BITS;
   localparam int unsigned COLS = 1 << COL_BITS;

   logic [COLS-1:0] cells [ROWS];

   always_ff @(posedge clk) begin
      if (we) begin
         cells[row][col] <= wdata;
      end
   end

   assign rdata = cells[row][col];

endmodule

// File: rtl/mux_addr_mem.sv
module mux_addr_mem
   import mam_pkg::*;
#(
   parameter int unsigned ROW_BITS    = 8,
   parameter int unsigned COL_BITS    = 8,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned PIN_BITS   = mam_max(ROW_BITS, COL_BITS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [PIN_BITS-1:0] addr_pins,
   input  logic                row_strobe_n,
   input  logic                col_strobe_n,
   input  logic                wr_n,
   input  logic                din,
   output logic                dout
);

   localparam int unsigned LANE_BITS = PIN_BITS + 2;

   if (ROW_BITS < 1 || ROW_BITS > 10) begin : g_bad_row
      $error("mux_addr_mem: ROW_BITS out of range 1..10");
   end
   if (COL_BITS < 1 || COL_BITS > 10) begin : g_bad_col
      $error("mux_addr_mem: COL_BITS out of range 1..10");
   end
   if (SYNC_STAGES > 4) begin : g_bad_sync
      $error("mux_addr_mem: SYNC_STAGES above 4");
   end

   logic [1:0]           strb_q;
   logic [LANE_BITS-1:0] lane_q;
   logic                 row_q;
   logic                 col_q;
   logic [PIN_BITS-1:0]  pins_q;
   logic                 rw_q;
   logic                 din_q;

   mam_delay #(
      .WIDTH  (2),
      .STAGES (SYNC_STAGES),
      .RST_VAL(2'b11)
   ) u_strb_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    ({row_strobe_n, col_strobe_n}),
      .q    (strb_q)
   );

   mam_delay #(
      .WIDTH  (LANE_BITS),
      .STAGES (SYNC_STAGES),
      .RST_VAL({LANE_BITS{1'b0}})
   ) u_lane_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    ({addr_pins, wr_n, din}),
      .q    (lane_q)
   );

   assign row_q  = strb_q[1];
   assign col_q  = strb_q[0];
   assign pins_q = lane_q[LANE_BITS-1:2];
   assign rw_q   = lane_q[1];
   assign din_q  = lane_q[0];

   logic [ROW_BITS-1:0] row_addr;
   logic [COL_BITS-1:0] col_addr;
   logic                row_fall;
   logic                col_fall;
   logic                go;
   mam_op_e             go_op;
   logic                go_din;

   mam_addr_regs #(
      .ROW_BITS(ROW_BITS),
      .COL_BITS(COL_BITS),
      .PIN_BITS(PIN_BITS)
   ) u_addr (
      .clk     (clk),
      .rst_n   (rst_n),
      .row_s   (row_q),
      .col_s   (col_q),
      .pins_s  (pins_q),
      .rw_s    (rw_q),
      .din_s   (din_q),
      .row_addr(row_addr),
      .col_addr(col_addr),
      .row_fall(row_fall),
      .col_fall(col_fall),
      .go      (go),
      .go_op   (go_op),
      .go_din  (go_din)
   );

   logic go_write;
   logic go_read;
   logic rd_bit;

   assign go_write = go & (go_op == OP_WRITE);
   assign go_read  = go & (go_op == OP_READ);

   mam_cell_array #(
      .ROW_BITS(ROW_BITS),
      .COL_BITS(COL_BITS)
   ) u_cells (
      .clk  (clk),
      .row  (row_addr),
      .col  (col_addr),
      .we   (go_write),
      .wdata(go_din),
      .rdata(rd_bit)
   );

   logic dout_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout_q <= 1'b0;
      end else if (col_q) begin
         dout_q <= 1'b0;
      end else if (go_read) begin
         dout_q <= rd_bit;
      end
   end

   assign dout = dout_q;

endmodule

// File: rtl/mam_checker.sv
module mam_checker #(
   parameter int unsigned ROW_BITS = 8,
   parameter int unsigned COL_BITS = 8,
   parameter int unsigned PIN_BITS = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic                row_q,
   input logic                col_q,
   input logic [PIN_BITS-1:0] pins_q,
   input logic                row_fall,
   input logic                col_fall,
   input logic [ROW_BITS-1:0] row_addr,
   input logic [COL_BITS-1:0] col_addr,
   input logic                go,
   input logic                go_write,
   input logic                dout
);

   p_reset_quiet_r1: assert property (@(posedge clk) !rst_n |=> (dout == 1'b0))
      else $error("R1 dout not cleared by reset");

   p_row_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      row_fall |=> (row_addr == $past(pins_q[ROW_BITS-1:0])))
      else $error("R2 row register mismatch");

   p_col_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
      go |-> (col_addr == $past(pins_q[COL_BITS-1:0])))
      else $error("R3 column register mismatch");

   p_read_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!col_q && !go) |=> $stable(dout))
      else $error("R5 dout changed without access");

   p_idle_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      col_q |=> (dout == 1'b0))
      else $error("R6 dout not zero while column strobe high");

   p_write_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      go_write |=> (dout == 1'b0))
      else $error("R6 dout raised by a write");

   p_no_access_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (col_fall && row_q) |=> !go)
      else $error("R7 access started with row strobe high");

endmodule

bind mux_addr_mem mam_checker #(
   .ROW_BITS(ROW_BITS),
   .COL_BITS(COL_BITS),
   .PIN_BITS(PIN_BITS)
) u_mam_checker (
   .clk     (clk),
   .rst_n   (rst_n),
   .row_q   (row_q),
   .col_q   (col_q),
   .pins_q  (pins_q),
   .row_fall(row_fall),
   .col_fall(col_fall),
   .row_addr(row_addr),
   .col_addr(col_addr),
   .go      (go),
   .go_write(go_write),
   .dout    (dout)
);

// File: tb/mux_addr_mem_test.sv
module mux_addr_mem_test;

   localparam int RB    = 4;
   localparam int CB    = 4;
   localparam int SYNC  = 2;
   localparam int NROW  = 1 << RB;
   localparam int NCOL  = 1 << CB;
   localparam int WAITC = SYNC + 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [CB-1:0] addr_pins = '0;
   logic          row_strobe_n = 1'b1;
   logic          col_strobe_n = 1'b1;
   logic          wr_n = 1'b1;
   logic          din = 1'b0;
   logic          dout;

   int checks = 0;
   int failures = 0;
   bit model [NROW*NCOL];

   always #10 clk = ~clk;

   mux_addr_mem #(
      .ROW_BITS   (RB),
      .COL_BITS   (CB),
      .SYNC_STAGES(SYNC)
   ) uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .addr_pins   (addr_pins),
      .row_strobe_n(row_strobe_n),
      .col_strobe_n(col_strobe_n),
      .wr_n        (wr_n),
      .din         (din),
      .dout        (dout)
   );

   function automatic bit pat(input int a);
      return bit'((((a * 37) >> 2) ^ (a >> 5)) & 1);
   endfunction

   task automatic check(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
      end
   endtask

   task automatic open_row(input int r);
      @(negedge clk);
      addr_pins = CB'(r);
      row_strobe_n = 1'b0;
      repeat (WAITC) @(negedge clk);
   endtask

   task automatic close_row();
      @(negedge clk);
      row_strobe_n = 1'b1;
      repeat (WAITC) @(negedge clk);
   endtask

   task automatic col_op(input int c, input bit w, input bit d, output logic got);
      @(negedge clk);
      addr_pins = CB'(c);
      wr_n = ~w;
      din = d;
      col_strobe_n = 1'b0;
      repeat (WAITC) @(negedge clk);
      got = dout;
      col_strobe_n = 1'b1;
      repeat (WAITC) @(negedge clk);
      check("R6 idle after column rise", dout, 1'b0);
   endtask

   task automatic sweep_read(input string req);
      logic got;
      for (int r = 0; r < NROW; r++) begin
         open_row(r);
         for (int c = 0; c < NCOL; c++) begin
            col_op(c, 1'b0, 1'b0, got);
            check(req, got, model[r*NCOL + c]);
         end
         close_row();
      end
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : main
      logic got;
      repeat (3) @(negedge clk);
      check("R1 dout during reset", dout, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 dout after reset", dout, 1'b0);

      // R4: write the pattern everywhere; R6: dout stays 0 during writes
      for (int r = 0; r < NROW; r++) begin
         open_row(r);
         for (int c = 0; c < NCOL; c++) begin
            model[r*NCOL + c] = pat(r*NCOL + c);
            col_op(c, 1'b1, model[r*NCOL + c], got);
            check("R6 dout during write", got, 1'b0);
         end
         close_row();
      end

      // R3 R5: full readback of word row*16+col
      sweep_read("R3 R5 readback");

      // R4 R9: invert even rows only, then read everything
      for (int r = 0; r < NROW; r += 2) begin
         open_row(r);
         for (int c = 0; c < NCOL; c++) begin
            model[r*NCOL + c] = ~model[r*NCOL + c];
            col_op(c, 1'b1, model[r*NCOL + c], got);
         end
         close_row();
      end
      sweep_read("R4 R9 mixed rows");

      // R2 R8: pins move while both strobes stay low
      open_row(9);
      @(negedge clk);
      addr_pins = CB'(5);
      wr_n = 1'b1;
      col_strobe_n = 1'b0;
      repeat (WAITC) @(negedge clk);
      check("R5 read row9 col5", dout, model[9*NCOL + 5]);
      addr_pins = CB'(12);
      wr_n = 1'b0;
      din = ~model[9*NCOL + 5];
      repeat (WAITC) @(negedge clk);
      check("R8 dout after pin change", dout, model[9*NCOL + 5]);
      col_strobe_n = 1'b1;
      repeat (WAITC) @(negedge clk);
      col_op(5, 1'b0, 1'b0, got);
      check("R8 word row9 col5 kept", got, model[9*NCOL + 5]);
      col_op(12, 1'b0, 1'b0, got);
      check("R2 R8 word row9 col12 kept", got, model[9*NCOL + 12]);
      close_row();

      // R7: column fall with row strobe high (row register still 9)
      @(negedge clk);
      addr_pins = CB'(3);
      wr_n = 1'b0;
      din = ~model[9*NCOL + 3];
      col_strobe_n = 1'b0;
      repeat (WAITC) @(negedge clk);
      check("R7 dout with row strobe high", dout, 1'b0);
      col_strobe_n = 1'b1;
      repeat (WAITC) @(negedge clk);
      open_row(9);
      col_op(3, 1'b0, 1'b0, got);
      check("R7 word row9 col3 unchanged", got, model[9*NCOL + 3]);
      close_row();

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule